// File: doc/BRIEF.md
# Memory Chip-Select Decoder

This block turns each CPU bus cycle of a 64 KB 65xx-style machine into one of three memory enables: the DRAM column strobe, the lower ROM enable and the upper ROM enable. It also produces a set of per-bank enables so that several ROM banks (the internal one and cartridges) can share the two ROM windows. All select outputs are combinational from the current address, direction and cycle qualifier. They are steered by three pieces of registered state: a read-source mode (ROM or RAM) and two bank numbers.

Software changes the state without any data path. Touching one of two fixed addresses flips the read-source mode. A write anywhere in a small 16-byte window stores a bank choice that is taken from the low address bits. Writes are always routed to DRAM, whatever the mode. The register and I/O area gets no memory select at all. A one-page window near the top of memory always reads from the internal bank, so the interrupt and bank-switching code stays reachable whatever cartridge is banked in.

The block has no data stream. Every pin is a plain control or status level, and no handshake applies.

Top module: `mem_chip_select`

## Requirements
- R1: After reset the block is in ROM read mode with both bank numbers zero. While reset is held, no select is asserted, because the cycle qualifier is low in that interval.
- R2: A qualified cycle with an address below 0x8000 asserts only `ram_sel`, for both reads and writes, in either mode.
- R3: In ROM mode, a qualified read of 0x8000..0xBFFF asserts only `lo_rom_sel`.
- R4: In ROM mode, a qualified read of 0xC000..0xFCFF or 0xFF40..0xFFFF asserts only `hi_rom_sel`.
- R5: A qualified read or write of 0xFF3F selects RAM mode from the following cycle onward. In RAM mode, reads of 0x8000..0xFCFF and 0xFF40..0xFFFF assert only `ram_sel`.
- R6: A qualified read or write of 0xFF3E selects ROM mode from the following cycle onward.
- R7: A qualified write to any address outside 0xFD00..0xFF3F asserts only `ram_sel`, in either mode.
- R8: A qualified cycle in 0xFD00..0xFF3F asserts none of `ram_sel`, `lo_rom_sel`, `hi_rom_sel` or the bank selects.
- R9: A qualified write to 0xFDD0..0xFDDF stores the lower bank from address bits [1:0] and the upper bank from address bits [3:2], effective on the next cycle. Reads in that window store nothing.
- R10: `lo_bank_sel` is the one-hot code of the lower bank (bit n for bank n) while `lo_rom_sel` is high, and zero otherwise. `hi_bank_sel` follows the same rule for the upper bank and `hi_rom_sel`.
- R11: A ROM-mode read of 0xFC00..0xFCFF drives `hi_bank_sel` to bank 0 (value 0001) whatever upper bank is stored.
- R12: While `cyc_en` is low, no select is asserted and neither the mode nor the banks change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | High during a valid CPU bus cycle |
| addr | input | 16 | CPU address |
| rnw | input | 1 | 1 = read, 0 = write |
| ram_sel | output | 1 | DRAM column strobe enable, active high |
| lo_rom_sel | output | 1 | Lower ROM window enable, active high |
| hi_rom_sel | output | 1 | Upper ROM window enable, active high |
| lo_bank_sel | output | 4 | One-hot bank enable for lower ROM reads |
| hi_bank_sel | output | 4 | One-hot bank enable for upper ROM reads |

## Verification
Two functions coincide on a single read of 0xFC00..0xFCFF made after a nonzero upper bank has been stored: the stored bank choice and the internal-page override both apply. The override must win and yield 0001. The bench stores bank 1 for the upper window, then reads the override page and an ordinary upper ROM address in successive cycles. It expects 0001 for the first read and 0010 for the second. A second coincidence is the cycle that touches a mode address: that cycle itself shows no select while the mode register updates. The next read must then reflect the new mode.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int ADDR_W = 16;

  // address map anchors (upper byte or full address)
  localparam logic [7:0]  KWIN_PAGE  = 8'hFC;
  localparam logic [15:0] IO_END     = 16'hFF40;
  localparam logic [15:0] MODE_ROM_A = 16'hFF3E;
  localparam logic [15:0] MODE_RAM_A = 16'hFF3F;
  localparam logic [11:0] BANK_WIN   = 12'hFDD;

  typedef enum logic [2:0] {
    RG_LOW_RAM,
    RG_ROM_LO,
    RG_ROM_HI,
    RG_KWIN,
    RG_IO,
    RG_ROM_TOP
  } region_e;
endpackage

// File: rtl/memsel_region.sv
module memsel_region
  import memsel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              hit_mode_rom,
  output logic              hit_mode_ram,
  output logic              hit_bank_win
);
  always_comb begin
    if (!addr[15])                    region = RG_LOW_RAM;
    else if (addr[15:14] == 2'b10)    region = RG_ROM_LO;
    else if (addr[15:8] < KWIN_PAGE)  region = RG_ROM_HI;
    else if (addr[15:8] == KWIN_PAGE) region = RG_KWIN;
    else if (addr < IO_END)           region = RG_IO;
    else                              region = RG_ROM_TOP;
  end

  assign hit_mode_rom = (addr == MODE_ROM_A);
  assign hit_mode_ram = (addr == MODE_RAM_A);
  assign hit_bank_win = (addr[15:4] == BANK_WIN);
endmodule

// File: rtl/memsel_ctl_regs.sv
module memsel_ctl_regs #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              rnw,
  input  logic              hit_mode_rom,
  input  logic              hit_mode_ram,
  input  logic              hit_bank_win,
  input  logic [2*BANK_W-1:0] bank_field,
  output logic              rom_mode,
  output logic [BANK_W-1:0] lo_bank,
  output logic [BANK_W-1:0] hi_bank
);
  logic bank_we;
  assign bank_we = cyc_en && !rnw && hit_bank_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_mode <= 1'b1;
    end else if (cyc_en) begin
      if (hit_mode_rom)      rom_mode <= 1'b1;
      else if (hit_mode_ram) rom_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_bank <= '0;
      hi_bank <= '0;
    end else if (bank_we) begin
      lo_bank <= bank_field[BANK_W-1:0];
      hi_bank <= bank_field[2*BANK_W-1:BANK_W];
    end
  end
endmodule

// File: rtl/memsel_bank_dec.sv
module memsel_bank_dec #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              en,
  input  logic [BANK_W-1:0] bank,
  output logic [NBANK-1:0]  sel
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign sel[g] = en && (bank == BANK_W'(g));
  end
endmodule

// File: rtl/mem_chip_select.sv
module mem_chip_select
  import memsel_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  output logic              ram_sel,
  output logic              lo_rom_sel,
  output logic              hi_rom_sel,
  output logic [NBANK-1:0]  lo_bank_sel,
  output logic [NBANK-1:0]  hi_bank_sel
);
  region_e           region;
  logic              hit_mode_rom, hit_mode_ram, hit_bank_win;
  logic              rom_mode;
  logic [BANK_W-1:0] lo_bank, hi_bank, hi_bank_eff;
  logic              upper_rom_area;

  memsel_region u_region (
    .addr         (addr),
    .region       (region),
    .hit_mode_rom (hit_mode_rom),
    .hit_mode_ram (hit_mode_ram),
    .hit_bank_win (hit_bank_win)
  );

  memsel_ctl_regs #(.BANK_W(BANK_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_en       (cyc_en),
    .rnw          (rnw),
    .hit_mode_rom (hit_mode_rom),
    .hit_mode_ram (hit_mode_ram),
    .hit_bank_win (hit_bank_win),
    .bank_field   (addr[2*BANK_W-1:0]),
    .rom_mode     (rom_mode),
    .lo_bank      (lo_bank),
    .hi_bank      (hi_bank)
  );

  assign upper_rom_area = (region == RG_ROM_HI) || (region == RG_KWIN) ||
                          (region == RG_ROM_TOP);

  always_comb begin
    ram_sel    = 1'b0;
    lo_rom_sel = 1'b0;
    hi_rom_sel = 1'b0;
    if (cyc_en && region != RG_IO) begin
      if (region == RG_LOW_RAM || !rnw || !rom_mode) ram_sel = 1'b1;
      else if (region == RG_ROM_LO)                  lo_rom_sel = 1'b1;
      else if (upper_rom_area)                       hi_rom_sel = 1'b1;
    end
  end

  // internal page always reads from bank 0
  assign hi_bank_eff = (region == RG_KWIN) ? '0 : hi_bank;

  memsel_bank_dec #(.BANK_W(BANK_W)) u_lo_dec (
    .en   (lo_rom_sel),
    .bank (lo_bank),
    .sel  (lo_bank_sel)
  );

  memsel_bank_dec #(.BANK_W(BANK_W)) u_hi_dec (
    .en   (hi_rom_sel),
    .bank (hi_bank_eff),
    .sel  (hi_bank_sel)
  );
endmodule

// File: rtl/mem_chip_select_chk.sv
module mem_chip_select_chk #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic [15:0]      addr,
  input logic             rnw,
  input logic             ram_sel,
  input logic             lo_rom_sel,
  input logic             hi_rom_sel,
  input logic [NBANK-1:0] lo_bank_sel,
  input logic [NBANK-1:0] hi_bank_sel
);
  logic in_io, any_sel;
  assign in_io   = (addr >= 16'hFD00) && (addr < 16'hFF40);
  assign any_sel = ram_sel || lo_rom_sel || hi_rom_sel ||
                   (|lo_bank_sel) || (|hi_bank_sel);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |-> !any_sel);

  p_low_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !addr[15]) |-> (ram_sel && !lo_rom_sel && !hi_rom_sel));

  p_write_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !rnw && !in_io) |-> (ram_sel && !lo_rom_sel && !hi_rom_sel));

  p_io_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && in_io) |-> !any_sel);

  p_ram_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && addr == 16'hFF3F) |=> !(lo_rom_sel || hi_rom_sel));

  p_rom_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && addr == 16'hFF3E) |=>
      (!(cyc_en && rnw && addr[15:14] == 2'b10) || lo_rom_sel));

  p_one_source_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, lo_rom_sel, hi_rom_sel}));

  p_lo_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lo_bank_sel) == (lo_rom_sel ? 1 : 0));

  p_hi_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hi_bank_sel) == (hi_rom_sel ? 1 : 0));

  p_kwin_bank0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rom_sel && addr[15:8] == 8'hFC) |-> (hi_bank_sel == NBANK'(1)));
endmodule

bind mem_chip_select mem_chip_select_chk #(.BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_en      (cyc_en),
  .addr        (addr),
  .rnw         (rnw),
  .ram_sel     (ram_sel),
  .lo_rom_sel  (lo_rom_sel),
  .hi_rom_sel  (hi_rom_sel),
  .lo_bank_sel (lo_bank_sel),
  .hi_bank_sel (hi_bank_sel)
);

// File: tb/test_mem_chip_select.sv
module test_mem_chip_select;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rnw = 1'b1;
  logic        ram_sel, lo_rom_sel, hi_rom_sel;
  logic [3:0]  lo_bank_sel, hi_bank_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mem_chip_select i_mem_chip_select (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .addr(addr), .rnw(rnw),
    .ram_sel(ram_sel), .lo_rom_sel(lo_rom_sel), .hi_rom_sel(hi_rom_sel),
    .lo_bank_sel(lo_bank_sel), .hi_bank_sel(hi_bank_sel)
  );

  // {rnw, addr, {ram,lo,hi}, lo_bank_sel, hi_bank_sel, requirement}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 16'h1234, 3'b100, 4'h0, 4'h0, 8'd2},   // R2 low RAM read
    {1'b0, 16'h4000, 3'b100, 4'h0, 4'h0, 8'd2},   // R2 low RAM write
    {1'b1, 16'h8000, 3'b010, 4'h1, 4'h0, 8'd3},   // R3
    {1'b1, 16'hBFFF, 3'b010, 4'h1, 4'h0, 8'd3},   // R3
    {1'b1, 16'hC000, 3'b001, 4'h0, 4'h1, 8'd4},   // R4
    {1'b1, 16'hFFFF, 3'b001, 4'h0, 4'h1, 8'd4},   // R4
    {1'b1, 16'hFD10, 3'b000, 4'h0, 4'h0, 8'd8},   // R8
    {1'b1, 16'hFF3D, 3'b000, 4'h0, 4'h0, 8'd8},   // R8
    {1'b0, 16'hA000, 3'b100, 4'h0, 4'h0, 8'd7},   // R7 write in ROM mode
    {1'b0, 16'hFDD6, 3'b000, 4'h0, 4'h0, 8'd9},   // R9 lo=2 hi=1
    {1'b1, 16'h9000, 3'b010, 4'h4, 4'h0, 8'd10},  // R10
    {1'b1, 16'hE000, 3'b001, 4'h0, 4'h2, 8'd10},  // R10
    {1'b1, 16'hFC40, 3'b001, 4'h0, 4'h1, 8'd11},  // R11 override
    {1'b1, 16'hFF80, 3'b001, 4'h0, 4'h2, 8'd10},  // R10
    {1'b1, 16'hFDDF, 3'b000, 4'h0, 4'h0, 8'd9},   // R9 read: no store
    {1'b1, 16'h9000, 3'b010, 4'h4, 4'h0, 8'd9},   // R9 bank kept
    {1'b1, 16'hFF3F, 3'b000, 4'h0, 4'h0, 8'd5},   // R5 go RAM mode
    {1'b1, 16'h9000, 3'b100, 4'h0, 4'h0, 8'd5},   // R5
    {1'b1, 16'hFC40, 3'b100, 4'h0, 4'h0, 8'd5},   // R5
    {1'b1, 16'hFFF0, 3'b100, 4'h0, 4'h0, 8'd5},   // R5
    {1'b1, 16'hFE00, 3'b000, 4'h0, 4'h0, 8'd8},   // R8 in RAM mode
    {1'b0, 16'hC000, 3'b100, 4'h0, 4'h0, 8'd7},   // R7
    {1'b0, 16'hFF3E, 3'b000, 4'h0, 4'h0, 8'd6},   // R6 write selects ROM
    {1'b1, 16'hC000, 3'b001, 4'h0, 4'h2, 8'd6},   // R6
    {1'b0, 16'hFDD0, 3'b000, 4'h0, 4'h0, 8'd9},   // R9 banks back to 0
    {1'b1, 16'hE000, 3'b001, 4'h0, 4'h1, 8'd9},   // R9
    {1'b0, 16'hFF40, 3'b100, 4'h0, 4'h0, 8'd7},   // R7 just past I/O
    {1'b0, 16'hFCFF, 3'b100, 4'h0, 4'h0, 8'd7}    // R7
  };

  task automatic drive(input logic en, input logic r, input logic [15:0] a);
    @(negedge clk);
    cyc_en = en;
    rnw    = r;
    addr   = a;
    #(CLK_P/4);
  endtask

  task automatic check(input int req, input logic [2:0] exp_src,
                       input logic [3:0] exp_lo, input logic [3:0] exp_hi);
    logic [10:0] act, exp;
    act = {ram_sel, lo_rom_sel, hi_rom_sel, lo_bank_sel, hi_bank_sel};
    exp = {exp_src, exp_lo, exp_hi};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%h rnw=%b act=%b exp=%b", req, addr, rnw, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: no selects during reset with the qualifier low
    #(CLK_P/4);
    check(1, 3'b000, 4'h0, 4'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][35], VEC[i][34:19]);
      check(int'(VEC[i][7:0]), VEC[i][18:16], VEC[i][15:12], VEC[i][11:8]);
    end

    // R12: qualifier low masks selects and blocks state changes
    drive(1'b0, 1'b1, 16'hFF3F);
    check(12, 3'b000, 4'h0, 4'h0);
    drive(1'b0, 1'b0, 16'hFDDF);
    check(12, 3'b000, 4'h0, 4'h0);
    drive(1'b0, 1'b1, 16'h1000);
    check(12, 3'b000, 4'h0, 4'h0);
    drive(1'b1, 1'b1, 16'h9000);
    check(12, 3'b010, 4'h1, 4'h0);   // still ROM mode, bank 0
    drive(1'b1, 1'b1, 16'hD000);
    check(12, 3'b001, 4'h0, 4'h1);

    // R1: reset clears mode and banks after they were changed
    drive(1'b1, 1'b0, 16'hFDDF);     // lo=3 hi=3
    drive(1'b1, 1'b1, 16'hFF3F);     // RAM mode
    drive(1'b1, 1'b1, 16'h9000);
    check(5, 3'b100, 4'h0, 4'h0);
    drive(1'b0, 1'b1, 16'h0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 16'h9000);
    check(1, 3'b010, 4'h1, 4'h0);
    drive(1'b1, 1'b1, 16'hE000);
    check(1, 3'b001, 4'h0, 4'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule